// File: doc/BRIEF.md
# APB Address-Window Fan-Out Decoder

This block sits between a single APB requester and a set of completers. The requester drives address, direction, enable and write data once. The block copies these to every completer port and raises the select line of only the one completer whose address window contains the transfer address. Read data, ready and error come back from that completer to the requester. Nothing is arbitrated, because only one requester exists and it starts every transfer.

Each window is a base and mask pair, given as parameters. An address belongs to port i when `(addr & MASK_i) == BASE_i`. The decision is made in the setup cycle and held for the enable cycle and any wait cycles. An address that falls in no window is answered by the block itself in its enable cycle, with an error. Completers that never stall can tie their ready input high.

Top module: `apb_fanout_decoder`

## Requirements
- R1: `cmp_addr`, `cmp_write`, `cmp_enable` and `cmp_wdata` equal `req_addr`, `req_write`, `req_enable` and `req_wdata` in every cycle, for every port.
- R2: In a setup cycle (`req_sel`=1, `req_enable`=0), bit i of `cmp_sel` is 1 exactly when `(req_addr & MASK[i]) == BASE[i]`. Port i's window occupies bits `[i*AW +: AW]` of the `BASE` and `MASK` parameters.
- R3: In enable and wait cycles, `cmp_sel` keeps the value decoded in the preceding setup cycle, even if `req_addr` changes.
- R4: While a mapped transfer is in enable or wait cycles, `req_ready`, `req_err` and `req_rdata` equal `cmp_ready[i]`, `cmp_err[i]` and `cmp_rdata[i*DW +: DW]` of the selected port i. `req_ready` is therefore 0 while that port stalls.
- R5: When `req_sel` is 0, `cmp_sel` is all zero, `req_rdata` is 0, `req_ready` is 1 and `req_err` is 0.
- R6: An enable cycle whose setup address matched no window completes in that same cycle: `req_ready`=1, `req_err`=1, `req_rdata`=0, and no bit of `cmp_sel` is set.
- R7: `cmp_sel` has at most one bit set in every cycle.
- R8: During reset and right after it, with `req_sel` low, `cmp_sel` is zero, `req_ready` is 1 and `req_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_sel | input | 1 | Requester select, marks a transfer in progress |
| req_enable | input | 1 | Requester enable, high in enable and wait cycles |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write data |
| req_rdata | output | DW | Read data returned to the requester |
| req_ready | output | 1 | Transfer completes on this edge when high |
| req_err | output | 1 | Error response for the completing transfer |
| cmp_sel | output | NPORT | One select line per completer |
| cmp_enable | output | 1 | Shared enable to all completers |
| cmp_write | output | 1 | Shared direction to all completers |
| cmp_addr | output | AW | Shared address to all completers |
| cmp_wdata | output | DW | Shared write data to all completers |
| cmp_rdata | input | NPORT*DW | Read data, port i at bits [i*DW +: DW] |
| cmp_ready | input | NPORT | Ready per completer (tie high if it never stalls) |
| cmp_err | input | NPORT | Error per completer |

## Verification
The bench uses the default build: four ports with 16-bit addresses and 32-bit data. Every window is 4 KiB (`MASK` 0xF000), with bases at 0x0000, 0x1000, 0x2000 and 0x4000. This leaves the regions starting at 0x3000 and from 0x5000 up unmapped. A sweep over all sixteen values of the upper address nibble, for reads and writes, with zero to two wait cycles and both error levels, reaches every port, the unmapped regions, stalls and error passing. A further pass changes the address during wait cycles to show that the select is held.

// File: rtl/apb_fanout_decoder.sv
module apb_fanout_decoder #(
  parameter int NPORT = 4,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter logic [NPORT*AW-1:0] BASE = {16'h4000, 16'h2000, 16'h1000, 16'h0000},
  parameter logic [NPORT*AW-1:0] MASK = {16'hF000, 16'hF000, 16'hF000, 16'hF000}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_sel,
  input  logic                req_enable,
  input  logic                req_write,
  input  logic [AW-1:0]       req_addr,
  input  logic [DW-1:0]       req_wdata,
  output logic [DW-1:0]       req_rdata,
  output logic                req_ready,
  output logic                req_err,
  output logic [NPORT-1:0]    cmp_sel,
  output logic                cmp_enable,
  output logic                cmp_write,
  output logic [AW-1:0]       cmp_addr,
  output logic [DW-1:0]       cmp_wdata,
  input  logic [NPORT*DW-1:0] cmp_rdata,
  input  logic [NPORT-1:0]    cmp_ready,
  input  logic [NPORT-1:0]    cmp_err
);

  function automatic bit windows_clash();
    for (int i = 0; i < NPORT; i++)
      for (int j = i + 1; j < NPORT; j++)
        if (((BASE[i*AW +: AW] ^ BASE[j*AW +: AW]) & MASK[i*AW +: AW] & MASK[j*AW +: AW]) == '0)
          return 1'b1;
    return 1'b0;
  endfunction

  if (windows_clash()) begin : g_clash
    $error("address windows overlap");
  end

  logic [NPORT-1:0] hit, held;
  logic [DW-1:0]    mux_rdata;
  logic             mux_ready, mux_err;

  wire setup  = req_sel & ~req_enable;
  wire access = req_sel & req_enable;
  wire miss   = access & ~|held;

  for (genvar i = 0; i < NPORT; i++) begin : g_win
    assign hit[i] = (req_addr & MASK[i*AW +: AW]) == BASE[i*AW +: AW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     held <= '0;
    else if (setup) held <= hit;
  end

  assign cmp_sel    = setup ? hit : (access ? held : '0);
  assign cmp_enable = req_enable;
  assign cmp_write  = req_write;
  assign cmp_addr   = req_addr;
  assign cmp_wdata  = req_wdata;

  always_comb begin
    mux_rdata = '0;
    mux_ready = 1'b0;
    mux_err   = 1'b0;
    for (int i = 0; i < NPORT; i++) begin
      if (cmp_sel[i]) begin
        mux_rdata = mux_rdata | cmp_rdata[i*DW +: DW];
        mux_ready = mux_ready | cmp_ready[i];
        mux_err   = mux_err | cmp_err[i];
      end
    end
  end

  assign req_rdata = mux_rdata;
  assign req_ready = (|cmp_sel) ? mux_ready : 1'b1;
  assign req_err   = miss | ((|cmp_sel) & mux_err);

endmodule

// File: rtl/apb_fanout_decoder_chk.sv
module apb_fanout_decoder_chk #(
  parameter int NPORT = 4,
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_sel,
  input logic                req_enable,
  input logic [DW-1:0]       req_rdata,
  input logic                req_ready,
  input logic                req_err,
  input logic [NPORT-1:0]    cmp_sel,
  input logic [NPORT-1:0]    cmp_ready
);

  p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmp_sel));

  p_hold_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_sel && !req_enable) ##1 (req_sel && req_enable) |-> cmp_sel == $past(cmp_sel));

  p_hold_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_sel && req_enable && !req_ready) ##1 (req_sel && req_enable) |-> cmp_sel == $past(cmp_sel));

  p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_sel && req_enable && (cmp_sel != '0) && ((cmp_sel & cmp_ready) == '0)) |-> !req_ready);

  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_sel |-> (cmp_sel == '0) && req_ready && !req_err && (req_rdata == '0));

  p_unmapped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_sel && req_enable && (cmp_sel == '0)) |-> req_ready && req_err && (req_rdata == '0));

endmodule

bind apb_fanout_decoder apb_fanout_decoder_chk #(.NPORT(NPORT), .AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_sel(req_sel), .req_enable(req_enable),
  .req_rdata(req_rdata), .req_ready(req_ready), .req_err(req_err),
  .cmp_sel(cmp_sel), .cmp_ready(cmp_ready)
);

// File: tb/apb_fanout_decoder_tb_top.sv
`timescale 1ns/1ps
module apb_fanout_decoder_tb_top;
  localparam int NPORT = 4, AW = 16, DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_sel = 1'b0, req_enable = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] req_rdata;
  logic req_ready, req_err;
  logic [NPORT-1:0] cmp_sel;
  logic cmp_enable, cmp_write;
  logic [AW-1:0] cmp_addr;
  logic [DW-1:0] cmp_wdata;
  logic [NPORT*DW-1:0] cmp_rdata;
  logic [NPORT-1:0] cmp_ready, cmp_err;
  logic rdy = 1'b1, ebit = 1'b0;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  for (genvar i = 0; i < NPORT; i++) begin : g_cmp
    assign cmp_rdata[i*DW +: DW] = {8'hC0 + 8'(i), 8'h00, cmp_addr};
  end
  assign cmp_ready = rdy ? '1 : '0;
  assign cmp_err   = ebit ? '1 : '0;

  apb_fanout_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .req_sel(req_sel), .req_enable(req_enable),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_rdata(req_rdata), .req_ready(req_ready), .req_err(req_err),
    .cmp_sel(cmp_sel), .cmp_enable(cmp_enable), .cmp_write(cmp_write),
    .cmp_addr(cmp_addr), .cmp_wdata(cmp_wdata), .cmp_rdata(cmp_rdata),
    .cmp_ready(cmp_ready), .cmp_err(cmp_err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int port_of(input logic [AW-1:0] a);
    int n = int'(a[15:12]);
    if (n < 3) return n;
    if (n == 4) return 3;
    return -1;
  endfunction

  function automatic logic [NPORT-1:0] sel_of(input int p);
    return (p < 0) ? '0 : NPORT'(1 << p);
  endfunction

  task automatic check_pass();
    chk(cmp_addr == req_addr && cmp_write == req_write && cmp_enable == req_enable && cmp_wdata == req_wdata,
        "R1 pass-through", {cmp_addr, cmp_wdata}, {req_addr, req_wdata});
  endtask

  task automatic xfer(input logic [AW-1:0] a, input bit wr, input int waits, input bit e, input bit move);
    int p = port_of(a);
    logic [NPORT-1:0] es = sel_of(p);
    @(negedge clk);
    req_sel = 1'b1; req_enable = 1'b0; req_addr = a; req_write = wr;
    req_wdata = {~a, a}; rdy = (waits == 0); ebit = 1'b0;
    #1;
    chk(cmp_sel == es, "R2 setup decode", 64'(cmp_sel), 64'(es));
    chk($onehot0(cmp_sel), "R7 one-hot", 64'(cmp_sel), 64'(es));
    check_pass();
    @(negedge clk);
    req_enable = 1'b1; ebit = e;
    if (move) req_addr = a ^ 16'h1000;
    #1;
    check_pass();
    if (p < 0) begin
      chk(cmp_sel == '0, "R6 no select", 64'(cmp_sel), 64'd0);
      chk(req_ready && req_err && req_rdata == '0, "R6 local error",
          {req_ready, req_err, req_rdata}, {2'b11, 32'd0});
    end else begin
      for (int k = 0; k < waits; k++) begin
        chk(cmp_sel == es, "R3 held select", 64'(cmp_sel), 64'(es));
        chk(!req_ready, "R4 stall", 64'(req_ready), 64'd0);
        @(negedge clk);
        #1;
      end
      rdy = 1'b1;
      #0.1;
      chk(cmp_sel == es, "R3 held select", 64'(cmp_sel), 64'(es));
      chk(req_ready && req_err == e && req_rdata == {8'hC0 + 8'(p), 8'h00, req_addr}, "R4 return mux",
          {req_ready, req_err, req_rdata}, {1'b1, e, 8'hC0 + 8'(p), 8'h00, req_addr});
    end
    @(negedge clk);
    req_sel = 1'b0; req_enable = 1'b0; ebit = 1'b1; rdy = 1'b0;
    #1;
    chk(cmp_sel == '0 && req_ready && !req_err && req_rdata == '0, "R5 idle",
        {cmp_sel, req_ready, req_err, req_rdata}, {4'd0, 2'b10, 32'd0});
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(cmp_sel == '0 && req_ready && !req_err, "R8 reset", {cmp_sel, req_ready, req_err}, {4'd0, 2'b10});
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(cmp_sel == '0 && req_ready && !req_err, "R8 after reset", {cmp_sel, req_ready, req_err}, {4'd0, 2'b10});
    for (int n = 0; n < 16; n++)
      for (int w = 0; w < 2; w++)
        xfer(AW'((n << 12) | (n * 16'h111) | (w * 5)), w[0], n % 3, n[0], 1'b0);
    for (int n = 0; n < 6; n++)
      xfer(AW'((n << 12) | 16'h0abc), 1'b0, 2, 1'b0, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule